// File: doc/BRIEF.md
# Register-File Exchange Sorter

This block keeps a small bank of unsigned values in its own register file and puts them into ascending order in place. A host fills the bank one entry per cycle by address while the `mode` input is low. It then raises `mode` to start the sort and waits for `done`. When it has seen `done`, it lowers `mode` and reads the ordered entries back by address.

The sort is an exchange sort with two nested indices. The outer index `i` walks from the first entry to the next-to-last. For each `i`, the inner index `j` walks over every later entry. A holding register keeps the smallest value found so far for position `i`, and a second holding register takes entry `j`. Whenever the first is strictly larger, the two entries trade places in one cycle. Each sort takes a fixed number of cycles, whatever the data.

Top module: `xchg_sorter`

## Requirements
- R1: When `mode` is 0 and the sorter is idle (`done` low, no sort running), a cycle with `wr_en` high stores `din` into entry `addr`.
- R2: A cycle with `rd_en` high and `mode` 0 puts entry `addr` on `dout` at the next clock edge. In every other cycle `dout` holds its value.
- R3: After a sort, entry 0 up to entry K-1 hold the values in non-decreasing unsigned order.
- R4: A sort keeps the loaded values as a permutation, duplicates included. Equal values are never exchanged, because only a strictly greater holding value triggers a swap.
- R5: The pairs are visited in the order (0,1),(0,2)..(0,K-1),(1,2)..(K-2,K-1). `done` first reads high K*K clock edges after the first edge that samples `mode` high.
- R6: `done` stays high while `mode` stays high, and drops at the first edge that samples `mode` low.
- R7: `wr_en` has no effect while a sort is running, while `done` is high, or while `mode` is 1.
- R8: `rst_n` low returns the controller to idle with `done` low and clears `dout`. It leaves the stored entries unchanged.
- R9: `rd_en` has no effect while `mode` is 1: `dout` keeps its previous value.
- R10: With K = 4, loading 3,2,4,1 and sorting leaves 1,2,3,4. The block can be loaded and sorted again any number of times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state and `dout` |
| din | input | N | Value to be written during loading |
| dout | output | N | Registered readback value |
| addr | input | L | Entry address for writes and reads |
| wr_en | input | 1 | Write strobe, honoured only in the idle load phase |
| mode | input | 1 | 0 = load and readback, 1 = sort request (level) |
| rd_en | input | 1 | Read strobe, honoured while `mode` is 0 |
| done | output | 1 | Sort finished. Held until `mode` falls |

## Verification
The bench builds the block with its defaults, N = 8 and L = 2, so it holds four entries and the whole pair order finishes in sixteen cycles. With that size, random vectors drawn from a narrow range give many duplicates, and the directed cases can cover already sorted input, reversed input and an all-equal bank. The bench also checks the exact cycle count, stray strobes in every controller phase and a reset between sorts.

// File: rtl/xs_pkg.sv
package xs_pkg;

    typedef enum logic [2:0] {
        XS_IDLE  = 3'd0,
        XS_GET_A = 3'd1,
        XS_GET_B = 3'd2,
        XS_CMP   = 3'd3,
        XS_DONE  = 3'd4
    } xs_state_e;

endpackage

// File: rtl/xs_regfile.sv
module xs_regfile #(
    parameter int N = 8,
    parameter int L = 2
) (
    input  logic         clk,
    input  logic         host_we,
    input  logic [L-1:0] host_addr,
    input  logic [N-1:0] host_din,
    input  logic         swap_we,
    input  logic [L-1:0] idx_a,
    input  logic [L-1:0] idx_b,
    input  logic [N-1:0] val_a,
    input  logic [N-1:0] val_b,
    output logic [N-1:0] rd_a,
    output logic [N-1:0] rd_b,
    output logic [N-1:0] rd_host
);
    localparam int K = 1 << L;

    logic [N-1:0] mem_q [K];
    logic [N-1:0] mem_d [K];

    always_comb begin
        for (int e = 0; e < K; e++) begin
            mem_d[e] = mem_q[e];
        end
        if (host_we) begin
            mem_d[host_addr] = host_din;
        end
        if (swap_we) begin
            mem_d[idx_a] = val_a;
            mem_d[idx_b] = val_b;
        end
    end

    // Storage is deliberately not reset: contents survive rst_n.
    always_ff @(posedge clk) begin
        for (int e = 0; e < K; e++) begin
            mem_q[e] <= mem_d[e];
        end
    end

    assign rd_a    = mem_q[idx_a];
    assign rd_b    = mem_q[idx_b];
    assign rd_host = mem_q[host_addr];
endmodule

// File: rtl/xs_ctrl.sv
module xs_ctrl
    import xs_pkg::*;
#(
    parameter int N = 8,
    parameter int L = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] ent_i,
    input  logic [N-1:0] ent_j,
    output logic [L-1:0] i_idx,
    output logic [L-1:0] j_idx,
    output logic         swap_we,
    output logic [N-1:0] new_i,
    output logic [N-1:0] new_j,
    output logic         idle,
    output logic         scanning,
    output logic         done
);
    localparam int          K      = 1 << L;
    localparam logic [L-1:0] LAST  = L'(K - 1);
    localparam logic [L-1:0] LAST_I = L'(K - 2);

    typedef struct packed {
        xs_state_e    st;
        logic [L-1:0] i;
        logic [L-1:0] j;
        logic [N-1:0] a;
        logic [N-1:0] b;
    } ctl_t;

    ctl_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        swap_we = 1'b0;
        unique case (r_q.st)
            XS_IDLE: begin
                if (start) begin
                    r_d.i  = '0;
                    r_d.st = XS_GET_A;
                end
            end
            XS_GET_A: begin
                r_d.a  = ent_i;
                r_d.j  = r_q.i + 1'b1;
                r_d.st = XS_GET_B;
            end
            XS_GET_B: begin
                r_d.b  = ent_j;
                r_d.st = XS_CMP;
            end
            XS_CMP: begin
                if (r_q.a > r_q.b) begin
                    swap_we = 1'b1;
                    r_d.a   = r_q.b;
                end
                if (r_q.j == LAST) begin
                    if (r_q.i == LAST_I) begin
                        r_d.st = XS_DONE;
                    end else begin
                        r_d.i  = r_q.i + 1'b1;
                        r_d.st = XS_GET_A;
                    end
                end else begin
                    r_d.j  = r_q.j + 1'b1;
                    r_d.st = XS_GET_B;
                end
            end
            XS_DONE: begin
                if (!start) begin
                    r_d.st = XS_IDLE;
                end
            end
            default: r_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= XS_IDLE;
            r_q.i  <= '0;
            r_q.j  <= '0;
            r_q.a  <= '0;
            r_q.b  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign i_idx    = r_q.i;
    assign j_idx    = r_q.j;
    assign new_i    = r_q.b;
    assign new_j    = r_q.a;
    assign idle     = (r_q.st == XS_IDLE);
    assign scanning = (r_q.st == XS_GET_B) || (r_q.st == XS_CMP);
    assign done     = (r_q.st == XS_DONE);
endmodule

// File: rtl/xchg_sorter.sv
module xchg_sorter #(
    parameter int N = 8,
    parameter int L = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout,
    input  logic [L-1:0] addr,
    input  logic         wr_en,
    input  logic         mode,
    input  logic         rd_en,
    output logic         done
);
    logic [L-1:0] i_idx, j_idx;
    logic [N-1:0] ent_i, ent_j, ent_host, new_i, new_j;
    logic         swap_we, idle, scanning, done_w, host_we;

    typedef struct packed {
        logic [N-1:0] dout;
    } out_t;

    out_t o_q, o_d;

    assign host_we = wr_en && !mode && idle;

    xs_regfile #(.N(N), .L(L)) u_rf (
        .clk      (clk),
        .host_we  (host_we),
        .host_addr(addr),
        .host_din (din),
        .swap_we  (swap_we),
        .idx_a    (i_idx),
        .idx_b    (j_idx),
        .val_a    (new_i),
        .val_b    (new_j),
        .rd_a     (ent_i),
        .rd_b     (ent_j),
        .rd_host  (ent_host)
    );

    xs_ctrl #(.N(N), .L(L)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mode),
        .ent_i   (ent_i),
        .ent_j   (ent_j),
        .i_idx   (i_idx),
        .j_idx   (j_idx),
        .swap_we (swap_we),
        .new_i   (new_i),
        .new_j   (new_j),
        .idle    (idle),
        .scanning(scanning),
        .done    (done_w)
    );

    always_comb begin
        o_d = o_q;
        if (rd_en && !mode) begin
            o_d.dout = ent_host;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.dout <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign dout = o_q.dout;
    assign done = done_w;
endmodule

module xs_checker #(
    parameter int N = 8,
    parameter int L = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode,
    input logic         rd_en,
    input logic         done,
    input logic [N-1:0] dout,
    input logic         idle,
    input logic         scanning,
    input logic [L-1:0] i_idx,
    input logic [L-1:0] j_idx
);
    // R6: done held while the request stays high
    a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode) |=> done);

    // R6: done released one edge after the request falls
    a_r6_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode) |=> !done);

    // R2, R9: readback register changes only on an honoured read
    a_r2_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !mode) |=> $stable(dout));

    // R5: inner index always lies past the outer index
    a_r5_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> (j_idx > i_idx));

    // R5: a request seen in idle leaves idle at once
    a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && mode) |=> !idle);

    // R8: done is low right after reset
    a_r8_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> !done);
endmodule

bind xchg_sorter xs_checker #(.N(N), .L(L)) u_xs_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .rd_en   (rd_en),
    .done    (done),
    .dout    (dout),
    .idle    (idle),
    .scanning(scanning),
    .i_idx   (i_idx),
    .j_idx   (j_idx)
);

// File: tb/xchg_sorter_bench.sv
`timescale 1ns/1ps
module xchg_sorter_bench;
    localparam int N = 8;
    localparam int L = 2;
    localparam int K = 1 << L;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] din = '0;
    logic [N-1:0] dout;
    logic [L-1:0] addr = '0;
    logic         wr_en = 1'b0;
    logic         mode = 1'b0;
    logic         rd_en = 1'b0;
    logic         done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [N-1:0] vec [K];
    logic [N-1:0] ref_v [K];

    always #2 clk = ~clk;

    xchg_sorter #(.N(N), .L(L)) u_xchg_sorter (
        .clk(clk), .rst_n(rst_n), .din(din), .dout(dout), .addr(addr),
        .wr_en(wr_en), .mode(mode), .rd_en(rd_en), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void make_ref();
        logic [N-1:0] t;
        for (int p = 0; p < K; p++) ref_v[p] = vec[p];
        for (int p = 0; p < K - 1; p++)
            for (int q = 0; q < K - 1 - p; q++)
                if (ref_v[q] > ref_v[q+1]) begin
                    t = ref_v[q]; ref_v[q] = ref_v[q+1]; ref_v[q+1] = t;
                end
    endfunction

    task automatic load_vec();
        for (int p = 0; p < K; p++) begin
            @(negedge clk);
            addr = L'(p); din = vec[p]; wr_en = 1'b1;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(input int a, output logic [N-1:0] v);
        @(negedge clk);
        addr = L'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = dout;
    endtask

    // raise mode, count edges until done, then drop mode
    task automatic run_sort(input bit chk_lat);
        int n = 0;
        @(negedge clk);
        mode = 1'b1;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!done && n < 200);
        if (chk_lat) check(n == K * K, "R5 latency", n, K * K);
        // R6: done stays high while mode held
        repeat (3) @(negedge clk);
        if (chk_lat) check(done == 1'b1, "R6 done hold", done, 1);
        mode = 1'b0;
        @(negedge clk);
        if (chk_lat) check(done == 1'b0, "R6 done release", done, 0);
    endtask

    task automatic verify_sorted(input string tag);
        logic [N-1:0] v;
        make_ref();
        for (int p = 0; p < K; p++) begin
            read_at(p, v);
            check(v == ref_v[p], tag, v, ref_v[p]);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R8 reset done", done, 0);
        check(dout == '0, "R8 reset dout", dout, 0);
        rst_n = 1'b1;

        // R10 directed: 3,2,4,1
        vec[0] = 3; vec[1] = 2; vec[2] = 4; vec[3] = 1;
        load_vec();
        // R1: loaded value visible before sort
        read_at(2, v);
        check(v == 8'd4, "R1 load", v, 4);
        run_sort(1'b1);
        for (int p = 0; p < K; p++) begin
            read_at(p, v);
            check(v == N'(p + 1), "R10 known vector", v, p + 1);
        end

        // R9: read ignored while mode high
        read_at(0, v);
        @(negedge clk);
        mode = 1'b1; addr = 2'd3; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(dout == 8'd1, "R9 read ignored", dout, 1);
        // finish that sort (data already ordered), checking R7 in busy and done phases
        @(negedge clk);
        addr = 2'd0; din = 8'hEE; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        while (!done) @(negedge clk);
        addr = 2'd1; din = 8'hDD; wr_en = 1'b1;
        @(negedge clk);
        mode = 1'b0; addr = 2'd2; din = 8'hCC;   // done still high this cycle
        @(negedge clk);
        wr_en = 1'b0;
        for (int p = 0; p < K; p++) begin
            read_at(p, v);
            check(v == N'(p + 1), "R7 write ignored", v, p + 1);
        end

        // R8: reset keeps contents
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8 done after reset", done, 0);
        check(dout == '0, "R8 dout after reset", dout, 0);
        rst_n = 1'b1;
        for (int p = 0; p < K; p++) begin
            read_at(p, v);
            check(v == N'(p + 1), "R8 contents kept", v, p + 1);
        end

        // directed corners: reversed, all equal, already sorted
        for (int p = 0; p < K; p++) vec[p] = N'(200 - p * 10);
        load_vec(); run_sort(1'b1); verify_sorted("R3 reversed");
        for (int p = 0; p < K; p++) vec[p] = 8'd77;
        load_vec(); run_sort(1'b1); verify_sorted("R4 all equal");
        for (int p = 0; p < K; p++) vec[p] = N'(p * 60);
        load_vec(); run_sort(1'b1); verify_sorted("R3 presorted");
        vec[0] = 8'hFF; vec[1] = 8'h00; vec[2] = 8'hFF; vec[3] = 8'h80;
        load_vec(); run_sort(1'b0); verify_sorted("R3 unsigned extremes");

        // random, half with a narrow range for duplicates
        for (int t = 0; t < 40; t++) begin
            for (int p = 0; p < K; p++)
                vec[p] = (t % 2 == 0) ? N'($urandom_range(0, 3)) : N'($urandom);
            load_vec();
            run_sort(t < 4);
            verify_sorted((t % 2 == 0) ? "R4 duplicates" : "R3 random");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule